// File: doc/BRIEF.md
# Voice Group Block Sequencer

This block plays back one voice group. A voice group is an ordered run of entries in a shared block table. Each entry names one fixed-size block of sample bytes, so several groups can reuse the same blocks in different orders. On a start request the sequencer takes a group number from 1 to 12 and reads that group's descriptor, which holds the first and last table index. It then walks the table from the first index to the last. For each entry it streams every byte of the named block out of a sample memory.

Output is paced by a sample tick. The format is selected for the whole chip. In 8-bit PCM, each tick gives out one byte. In 4-bit ADPCM, each byte yields two codes, one per tick; decoding those codes is left to a later stage. All three memories (descriptor, table and sample) are read through synchronous ports with one cycle of latency. A one-byte prefetch keeps the next byte ready before it is needed. An abort input drops playback at once, and a done pulse marks the end of a complete playback.

Top module: `vgroup_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `sample_valid_o` and all three read strobes are low.
- R2: When idle, a `start_i` pulse with `group_i` in 1..12 reads the descriptor in the same cycle, at address `group_i`-1, and sets `busy_o` on the next cycle. A start with `group_i` of 0 or above 12 is ignored. So is a start while busy.
- R3: The table is read at every index from the descriptor's first index (the low field) to its last index (the high field), inclusive and in increasing order. Each index is read exactly once.
- R4: For a block number `b` read from the table, the sample memory is read at `b*BLOCK_BYTES + k` for k = 0 .. BLOCK_BYTES-1, in increasing order, with the block number in the upper address bits.
- R5: In PCM mode (`adpcm_i`=0), each tick that finds a byte ready raises `sample_valid_o` for one cycle, on the cycle after the tick. `sample_o` carries the full byte.
- R6: In ADPCM mode (`adpcm_i`=1), each byte gives two samples: bits [3:0] first, then bits [7:4]. Each code appears on `sample_o[3:0]`, and `sample_o[7:4]` is zero.
- R7: `done_o` is a one-cycle pulse in the same cycle as the `sample_valid_o` of the group's final sample. `busy_o` is low in that cycle.
- R8: When `abort_i` is high, the next cycle shows `busy_o` low. After that, no sample, done pulse or memory read follows until a new start.
- R9: When ticks are at least 4 cycles apart, and the first tick comes at least 8 cycles after start, no sample is lost or repeated. The samples out equal the group's bytes (or nibbles) in table order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request pulse |
| group_i | input | 4 | Group number, valid 1..12 |
| abort_i | input | 1 | Stop playback immediately |
| adpcm_i | input | 1 | Chip-wide format: 1 = two 4-bit codes per byte, 0 = 8-bit PCM |
| tick_i | input | 1 | Sample tick |
| desc_rd_o | output | 1 | Descriptor read strobe |
| desc_addr_o | output | 4 | Descriptor address (group - 1) |
| desc_first_i | input | 10 | First table index, valid the cycle after the read |
| desc_last_i | input | 10 | Last table index, valid the cycle after the read |
| tbl_rd_o | output | 1 | Block table read strobe |
| tbl_addr_o | output | 10 | Block table index |
| tbl_blk_i | input | 7 | Block number, valid the cycle after the read |
| smp_rd_o | output | 1 | Sample memory read strobe |
| smp_addr_o | output | 16 | Sample byte address {block, offset} |
| smp_data_i | input | 8 | Sample byte, valid the cycle after the read |
| sample_o | output | 8 | Output sample or code |
| sample_valid_o | output | 1 | Sample valid pulse |
| busy_o | output | 1 | Playback in progress |
| done_o | output | 1 | Playback finished pulse |

## Verification
The hardest situation to reach is the hand-over at a block boundary under the tightest tick spacing. At that point the table read for the next entry, the refill of the prefetch byte and a tick that drains the current byte all fall within a few cycles. The bench builds descriptors whose runs cross many boundaries, including single-entry groups and a group that ends at the top table index. It plays them with ticks fixed at the minimum spacing of 4 cycles and also with randomly spaced ticks. The full stream and every read address are compared with the sequence the bench expects. Abort is fired in the middle of a stream, and start requests are injected while the block is busy.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_DESC = 3'd1,
    F_TBL  = 3'd2,
    F_BYTE = 3'd3,
    F_END  = 3'd4
  } fetch_st_t;

  // Sample value for one tick: full byte, or one nibble zero-extended.
  function automatic logic [7:0] pick_sample(input logic [7:0] b,
                                             input logic adpcm,
                                             input logic hi);
    if (!adpcm)  return b;
    else if (hi) return {4'b0000, b[7:4]};
    else         return {4'b0000, b[3:0]};
  endfunction

  // True when a group number lies in 1..n.
  function automatic logic group_ok(input int unsigned g, input int unsigned n);
    return (g >= 1) && (g <= n);
  endfunction

  // Sample byte address from block number and byte offset.
  function automatic int unsigned byte_addr(input int unsigned blk,
                                            input int unsigned ofs,
                                            input int unsigned bytes);
    return blk * bytes + ofs;
  endfunction

endpackage

// File: rtl/vgs_fetch.sv
module vgs_fetch
  import vgs_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int BLK_W       = 7,
  parameter int TIDX_W      = 10,
  parameter int GRP_W       = 4,
  parameter int NUM_GROUPS  = 12,
  localparam int OFS_W      = $clog2(BLOCK_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [GRP_W-1:0]        group_i,
  input  logic                    abort_i,
  input  logic                    fin_i,
  output logic                    accept_o,
  output logic                    desc_rd_o,
  output logic [GRP_W-1:0]        desc_addr_o,
  input  logic [TIDX_W-1:0]       desc_first_i,
  input  logic [TIDX_W-1:0]       desc_last_i,
  output logic                    tbl_rd_o,
  output logic [TIDX_W-1:0]       tbl_addr_o,
  input  logic [BLK_W-1:0]        tbl_blk_i,
  output logic                    smp_rd_o,
  output logic [BLK_W+OFS_W-1:0]  smp_addr_o,
  input  logic [7:0]              smp_data_i,
  input  logic                    take_i,
  output logic [7:0]              hold_o,
  output logic                    hold_v_o,
  output logic                    end_o,
  output logic                    busy_o
);

  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(BLOCK_BYTES - 1);

  fetch_st_t          st;
  logic [TIDX_W-1:0]  entry, last_e;
  logic [BLK_W-1:0]   blk;
  logic [OFS_W-1:0]   ofs;
  logic               pend;
  logic [7:0]         hold;
  logic               hold_v;

  // named events
  logic byte_in;     // a sample byte returns this cycle
  logic blk_wrap;    // that byte is the last of its block
  logic run_last;    // current entry is the group's last entry

  assign accept_o    = (st == F_IDLE) && start_i && !abort_i &&
                       group_ok(int'(group_i), NUM_GROUPS);
  assign desc_rd_o   = accept_o;
  assign desc_addr_o = group_i - GRP_W'(1);

  assign byte_in  = (st == F_BYTE) && pend;
  assign blk_wrap = byte_in && (ofs == OFS_LAST);
  assign run_last = (entry == last_e);

  assign tbl_rd_o   = (st == F_DESC) || (blk_wrap && !run_last);
  assign tbl_addr_o = (st == F_DESC) ? desc_first_i : entry + TIDX_W'(1);
  assign smp_rd_o   = (st == F_BYTE) && !hold_v && !pend;
  assign smp_addr_o = {blk, ofs};

  assign hold_o   = hold;
  assign hold_v_o = hold_v;
  assign end_o    = (st == F_END);
  assign busy_o   = (st != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || abort_i || fin_i) begin
      st     <= F_IDLE;
      pend   <= 1'b0;
      hold_v <= 1'b0;
      if (!rst_n) begin
        entry  <= '0;
        last_e <= '0;
        blk    <= '0;
        ofs    <= '0;
        hold   <= '0;
      end
    end else begin
      if (take_i) hold_v <= 1'b0;
      unique case (st)
        F_IDLE: if (accept_o) st <= F_DESC;
        F_DESC: begin
          entry  <= desc_first_i;
          last_e <= desc_last_i;
          st     <= F_TBL;
        end
        F_TBL: begin
          blk <= tbl_blk_i;
          ofs <= '0;
          st  <= F_BYTE;
        end
        F_BYTE: begin
          if (smp_rd_o) pend <= 1'b1;
          if (byte_in) begin
            pend   <= 1'b0;
            hold   <= smp_data_i;
            hold_v <= 1'b1;
            ofs    <= ofs + OFS_W'(1);
            if (blk_wrap) begin
              if (run_last) st <= F_END;
              else begin
                entry <= entry + TIDX_W'(1);
                st    <= F_TBL;
              end
            end
          end
        end
        F_END: st <= F_END;
        default: st <= F_IDLE;
      endcase
    end
  end

  // a returning byte never lands on a full holding register
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !hold_v);

  // a table read beyond the descriptor's last index never happens
  assert_tbl_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_o && st == F_BYTE) |-> (entry < last_e));

  // abort empties the sequencer on the following cycle
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !smp_rd_o && !tbl_rd_o));

  // an accepted start leaves idle on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o);

endmodule

// File: rtl/vgs_emit.sv
module vgs_emit
  import vgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       tick_i,
  input  logic       adpcm_i,
  input  logic [7:0] hold_i,
  input  logic       hold_v_i,
  input  logic       end_i,
  output logic       take_o,
  output logic       fin_o,
  output logic [7:0] sample_o,
  output logic       valid_o
);

  logic [7:0] cur;
  logic       cur_v;
  logic       phase;     // 1 = high nibble is next

  // named events
  logic emit;            // a tick finds a sample ready
  logic byte_last;       // this emission finishes the current byte
  logic need_load;       // current byte register is free after this cycle

  assign emit      = tick_i && cur_v;
  assign byte_last = !adpcm_i || phase;
  assign need_load = (emit && byte_last) || !cur_v;
  assign take_o    = need_load && hold_v_i && !clear_i;
  assign fin_o     = emit && byte_last && !hold_v_i && end_i && !clear_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cur_v   <= 1'b0;
      phase   <= 1'b0;
      valid_o <= 1'b0;
      if (!rst_n) begin
        cur      <= '0;
        sample_o <= '0;
      end
    end else begin
      valid_o <= emit;
      if (emit) sample_o <= pick_sample(cur, adpcm_i, phase);
      if (emit && !byte_last) begin
        phase <= 1'b1;
      end else if (need_load) begin
        phase <= 1'b0;
        cur_v <= hold_v_i;
        if (hold_v_i) cur <= hold_i;
      end
    end
  end

  // output strobe only follows a tick
  assert_valid_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(tick_i));

  // coded samples never carry upper bits
  assert_code_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(adpcm_i)) |-> (sample_o[7:4] == 4'h0));

endmodule

// File: rtl/vgroup_seq.sv
module vgroup_seq
  import vgs_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int NUM_BLOCKS  = 128,
  parameter int TABLE_DEPTH = 960,
  parameter int NUM_GROUPS  = 12,
  localparam int OFS_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int TIDX_W     = $clog2(TABLE_DEPTH),
  localparam int GRP_W      = $clog2(NUM_GROUPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [GRP_W-1:0]        group_i,
  input  logic                    abort_i,
  input  logic                    adpcm_i,
  input  logic                    tick_i,
  output logic                    desc_rd_o,
  output logic [GRP_W-1:0]        desc_addr_o,
  input  logic [TIDX_W-1:0]       desc_first_i,
  input  logic [TIDX_W-1:0]       desc_last_i,
  output logic                    tbl_rd_o,
  output logic [TIDX_W-1:0]       tbl_addr_o,
  input  logic [BLK_W-1:0]        tbl_blk_i,
  output logic                    smp_rd_o,
  output logic [BLK_W+OFS_W-1:0]  smp_addr_o,
  input  logic [7:0]              smp_data_i,
  output logic [7:0]              sample_o,
  output logic                    sample_valid_o,
  output logic                    busy_o,
  output logic                    done_o
);

  logic       accept, take, fin, fetch_end;
  logic [7:0] hold;
  logic       hold_v;
  logic       emit_clear;

  assign emit_clear = abort_i || accept;

  vgs_fetch #(
    .BLOCK_BYTES (BLOCK_BYTES),
    .BLK_W       (BLK_W),
    .TIDX_W      (TIDX_W),
    .GRP_W       (GRP_W),
    .NUM_GROUPS  (NUM_GROUPS)
  ) fetch_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .group_i      (group_i),
    .abort_i      (abort_i),
    .fin_i        (fin),
    .accept_o     (accept),
    .desc_rd_o    (desc_rd_o),
    .desc_addr_o  (desc_addr_o),
    .desc_first_i (desc_first_i),
    .desc_last_i  (desc_last_i),
    .tbl_rd_o     (tbl_rd_o),
    .tbl_addr_o   (tbl_addr_o),
    .tbl_blk_i    (tbl_blk_i),
    .smp_rd_o     (smp_rd_o),
    .smp_addr_o   (smp_addr_o),
    .smp_data_i   (smp_data_i),
    .take_i       (take),
    .hold_o       (hold),
    .hold_v_o     (hold_v),
    .end_o        (fetch_end),
    .busy_o       (busy_o)
  );

  vgs_emit emit_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (emit_clear),
    .tick_i   (tick_i),
    .adpcm_i  (adpcm_i),
    .hold_i   (hold),
    .hold_v_i (hold_v),
    .end_i    (fetch_end),
    .take_o   (take),
    .fin_o    (fin),
    .sample_o (sample_o),
    .valid_o  (sample_valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= fin;
  end

  // completion coincides with the final sample and the return to idle
  assert_done_with_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sample_valid_o && !busy_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // nothing is emitted after an abort
  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!sample_valid_o && !done_o));

endmodule

// File: tb/vgroup_seq_tb.sv
module vgroup_seq_tb_top;

  localparam int BB = 8, NB = 16, TD = 64, NG = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, abort = 1'b0, adpcm = 1'b0, tick = 1'b0;
  logic [3:0] group = '0;
  logic       desc_rd, tbl_rd, smp_rd;
  logic [3:0] desc_addr;
  logic [5:0] d_first, d_last, tbl_addr;
  logic [3:0] tbl_blk;
  logic [6:0] smp_addr;
  logic [7:0] smp_data, sample;
  logic       svalid, busy, done;

  always #4 clk = ~clk;

  vgroup_seq #(.BLOCK_BYTES(BB), .NUM_BLOCKS(NB), .TABLE_DEPTH(TD), .NUM_GROUPS(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .group_i(group), .abort_i(abort),
    .adpcm_i(adpcm), .tick_i(tick), .desc_rd_o(desc_rd), .desc_addr_o(desc_addr),
    .desc_first_i(d_first), .desc_last_i(d_last), .tbl_rd_o(tbl_rd),
    .tbl_addr_o(tbl_addr), .tbl_blk_i(tbl_blk), .smp_rd_o(smp_rd),
    .smp_addr_o(smp_addr), .smp_data_i(smp_data), .sample_o(sample),
    .sample_valid_o(svalid), .busy_o(busy), .done_o(done));

  // memory models, one cycle read latency
  logic [7:0] smem [NB*BB];
  logic [3:0] tmem [TD];
  logic [5:0] dfirst [NG];
  logic [5:0] dlast [NG];

  always @(posedge clk) begin
    if (smp_rd)  smp_data <= smem[smp_addr];
    if (tbl_rd)  tbl_blk  <= tmem[tbl_addr];
    if (desc_rd) begin d_first <= dfirst[desc_addr]; d_last <= dlast[desc_addr]; end
  end

  int n_chk = 0, n_bad = 0;
  int exp_s [1024];
  int exp_t [64];
  int exp_a [512];
  int exp_n, exp_tn, exp_an;
  int got, tg, ag;
  bit done_seen, mon_on = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // expected stream from the requirements: entries in order, bytes in order, low nibble first
  task automatic build(input int g, input bit adp);
    exp_n = 0; exp_tn = 0; exp_an = 0;
    for (int e = int'(dfirst[g-1]); e <= int'(dlast[g-1]); e++) begin
      exp_t[exp_tn++] = e;
      for (int o = 0; o < BB; o++) begin
        int a;
        a = int'(tmem[e]) * BB + o;
        exp_a[exp_an++] = a;
        if (adp) begin
          exp_s[exp_n++] = int'(smem[a] & 8'h0f);
          exp_s[exp_n++] = int'(smem[a] >> 4);
        end else exp_s[exp_n++] = int'(smem[a]);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (svalid) begin
        chk(got < exp_n && int'(sample) == exp_s[got], "R5/R6/R9 sample", int'(sample),
            (got < exp_n) ? exp_s[got] : -1);
        got++;
      end
      if (tbl_rd) begin
        chk(tg < exp_tn && int'(tbl_addr) == exp_t[tg], "R3 table index", int'(tbl_addr),
            (tg < exp_tn) ? exp_t[tg] : -1);
        tg++;
      end
      if (smp_rd) begin
        chk(ag < exp_an && int'(smp_addr) == exp_a[ag], "R4 byte address", int'(smp_addr),
            (ag < exp_an) ? exp_a[ag] : -1);
        ag++;
      end
      if (done) begin
        chk(svalid && !busy && got == exp_n, "R7 done with last sample", got, exp_n);
        done_seen = 1;
      end
    end
  end

  task automatic pulse_start(input int g);
    start = 1; group = 4'(g);
    @(negedge clk);
    start = 0;
  endtask

  task automatic play(input int g, input bit adp, input int gmin, input int gmax, input bit poke);
    int n;
    build(g, adp);
    got = 0; tg = 0; ag = 0; done_seen = 0; mon_on = 1;
    adpcm = adp;
    @(negedge clk);
    chk(desc_rd == 0, "R2 no read before start", int'(desc_rd), 0);
    start = 1; group = 4'(g);
    #1 chk(desc_rd && int'(desc_addr) == g - 1, "R2 descriptor address", int'(desc_addr), g - 1);
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R2 busy after start", int'(busy), 1);
    repeat (7) @(negedge clk);
    n = 0;
    while (!done_seen && n < 400) begin
      int gap;
      gap = gmin + int'($urandom % 32'(gmax - gmin + 1));
      repeat (gap - 1) @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
      n++;
      if (poke && n == 5) pulse_start((g % NG) + 1);
    end
    repeat (3) @(negedge clk);
    chk(done_seen, "R7 done seen", int'(done_seen), 1);
    chk(got == exp_n, "R9 sample count", got, exp_n);
    chk(tg == exp_tn, "R3 table read count", tg, exp_tn);
    chk(ag == exp_an, "R4 byte read count", ag, exp_an);
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < NB*BB; i++) smem[i] = 8'($urandom);
    for (int i = 0; i < TD; i++) tmem[i] = 4'($urandom);
    for (int i = 0; i < NG; i++) begin
      int f, l;
      f = int'($urandom % 50);
      l = f + int'($urandom % 6);
      dfirst[i] = 6'(f); dlast[i] = 6'(l);
    end
    dfirst[0] = 6'd10; dlast[0] = 6'd10;   // single entry
    dfirst[11] = 6'd58; dlast[11] = 6'd63; // ends at top index
    dfirst[1] = 6'd20; dlast[1] = 6'd23;   // shares blocks with others
    dfirst[2] = 6'd22; dlast[2] = 6'd25;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !svalid && !desc_rd && !tbl_rd && !smp_rd, "R1 reset idle",
        int'({busy, done, svalid, desc_rd, tbl_rd, smp_rd}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !svalid, "R1 idle after reset", int'({busy, svalid}), 0);

    // out-of-range group numbers
    foreach (exp_t[k]) if (k < 2) begin
      bit seen;
      seen = 0;
      start = 1; group = (k == 0) ? 4'd0 : 4'd13;
      #1 seen = desc_rd;
      @(negedge clk);
      start = 0;
      repeat (4) begin seen |= busy | desc_rd; @(negedge clk); end
      chk(!seen, "R2 bad group ignored", int'(seen), 0);
    end

    play(1, 0, 4, 4, 0);
    play(12, 1, 4, 4, 0);
    play(2, 0, 4, 4, 1);
    play(3, 1, 4, 9, 1);
    for (int r = 0; r < 16; r++)
      play(1 + int'($urandom % NG), 1'($urandom), 4, 12, 1'($urandom));

    // abort in the middle of a stream
    begin
      bit bad;
      build(12, 1);
      adpcm = 1;
      pulse_start(12);
      repeat (8) @(negedge clk);
      repeat (6) begin tick = 1; @(negedge clk); tick = 0; repeat (4) @(negedge clk); end
      abort = 1;
      @(negedge clk);
      abort = 0;
      chk(!busy, "R8 idle after abort", int'(busy), 0);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        tick = (i % 4 == 0);
        @(negedge clk);
        bad |= svalid | done | smp_rd | tbl_rd | busy;
      end
      tick = 0;
      chk(!bad, "R8 quiet after abort", int'(bad), 0);
    end
    play(5, 0, 4, 6, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule